// File: doc/BRIEF.md
# Byte-Serial Logical-OR Instruction Decoder

This block takes a stream of instruction bytes, one byte per cycle, over a valid/ready handshake. It decodes one instruction of the bitwise inclusive-OR family in 64-bit mode. An instruction can start with optional operand-size (66h) and lock (F0h) prefixes in any order, then an optional REX byte. The opcode follows, then a ModRM byte for the forms that use one, then an immediate of 1, 2 or 4 bytes.

When the last byte of an instruction has been taken, the block presents one decoded record. The record holds the operand width, the destination and source selectors with their memory, immediate and high-byte flags, the immediate extended to 64 bits, and an invalid-opcode flag. The record stays on the outputs until the consumer accepts it. No input byte is taken while a record is waiting.

The block does not consume SIB or displacement bytes. It computes no address and executes nothing.

Top module: `or_byte_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the block waits for the first byte of an instruction.
- R2: Bytes 66h and F0h are prefixes and may come in any order, any number of times. A byte 40h–4Fh is REX (bit 3 = W, bit 2 = R, bit 0 = B), and the byte after it is always taken as the opcode. A 66h or F0h byte in that position is therefore an unknown opcode.
- R3: `out_width` encodes the operand width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Byte forms (0Ch, 80h, 08h, 0Ah) are 8-bit. For the other forms, REX.W selects 64-bit; otherwise 66h selects 16-bit; otherwise the width is 32-bit.
- R4: Opcode 0Ch reads a 1-byte immediate and opcode 0Dh reads a 2-byte immediate at 16-bit width or a 4-byte immediate otherwise. In both forms the destination is register 0 and the source is the immediate.
- R5: Opcodes 80h, 81h and 83h with ModRM reg = 1 take the destination from {REX.B, ModRM[2:0]}. The destination is memory when ModRM[7:6] ≠ 3. The immediate is 1 byte for 80h and 83h. For 81h it is 2 bytes at 16-bit width and 4 bytes otherwise.
- R6: `out_imm` is the immediate sign-extended from its own length and then cut to the operand width, with every bit above that width zero.
- R7: Opcodes 08h/09h write the r/m operand from the reg operand, and 0Ah/0Bh write the reg operand from the r/m operand. The reg selector is {REX.R, ModRM[5:3]}, and the r/m operand is memory when ModRM[7:6] ≠ 3.
- R8: A register operand of an 8-bit instruction with selector 4–7 is flagged as a high-byte register only when no REX byte was present.
- R9: The lock prefix together with a register destination (ModRM[7:6] = 3 in a destination-r/m form, any 0Ah/0Bh form, or 0Ch/0Dh) sets `out_ud`. The lock prefix with a memory destination does not set it.
- R10: An opcode outside {08h–0Dh, 80h, 81h, 83h} ends the instruction at once with `out_ud` set. For 80h/81h/83h, a ModRM reg field other than 1 ends the instruction after the ModRM byte with `out_ud` set. In both cases no immediate byte is consumed.
- R11: A record stays valid and unchanged until `out_ready` is 1, and `in_ready` stays 0 while it waits. After acceptance the next instruction is decoded with all prefix state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_width | output | 2 | Operand width code |
| out_dst | output | 4 | Destination selector |
| out_dst_mem | output | 1 | Destination is memory |
| out_dst_hi | output | 1 | Destination is a high-byte register |
| out_src | output | 4 | Source selector (0 for an immediate source) |
| out_src_mem | output | 1 | Source is memory |
| out_src_imm | output | 1 | Source is the immediate |
| out_src_hi | output | 1 | Source is a high-byte register |
| out_imm | output | 64 | Extended immediate |
| out_ud | output | 1 | Invalid-opcode indication |

## Verification
Every opcode form is driven with prefix mixes that put REX.W, 66h, REX.R and REX.B against each other. These cases separate the width priority and the selector extension. Immediates with their top bit set or clear, at each length, separate sign extension from zero extension and show the cut to the operand width. Lock is applied to both register and memory destinations. Unknown opcodes and a wrong group reg field are each followed by a normal instruction, which shows that no immediate bytes were swallowed. A long wait with a byte offered during the stall shows that the record is held and that no input is taken.

// File: rtl/ordec_pkg.sv
package ordec_pkg;

   localparam logic [7:0] PFX_OSZ  = 8'h66;
   localparam logic [7:0] PFX_LOCK = 8'hF0;
   localparam logic [3:0] REX_HI   = 4'h4;

   typedef enum logic [1:0] {
      OSZ_8  = 2'd0,
      OSZ_16 = 2'd1,
      OSZ_32 = 2'd2,
      OSZ_64 = 2'd3
   } osz_e;

   typedef enum logic [1:0] {
      IMMK_NONE = 2'd0,
      IMMK_BYTE = 2'd1,
      IMMK_FULL = 2'd2
   } immk_e;

   typedef struct packed {
      logic  known;
      logic  has_modrm;
      logic  grp;
      logic  byte_op;
      logic  reg_is_dst;
      immk_e immk;
   } opc_attr_t;

   typedef enum logic [2:0] {
      ST_PFX   = 3'd0,
      ST_OPC   = 3'd1,
      ST_MODRM = 3'd2,
      ST_IMM   = 3'd3,
      ST_DONE  = 3'd4
   } st_e;

   // immediate byte count for a given kind and width
   function automatic logic [2:0] imm_bytes(immk_e k, osz_e w);
      logic [2:0] n;
      case (k)
         IMMK_BYTE: n = 3'd1;
         IMMK_FULL: n = (w == OSZ_16) ? 3'd2 : 3'd4;
         default:   n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/ordec_opc_class.sv
module ordec_opc_class
   import ordec_pkg::*;
(
   input  logic [7:0] opc,
   output opc_attr_t  attr
);

   always_comb begin
      attr = '0;
      attr.immk = IMMK_NONE;
      case (opc)
         8'h08, 8'h0A: begin
            attr.known      = 1'b1;
            attr.has_modrm  = 1'b1;
            attr.byte_op    = 1'b1;
            attr.reg_is_dst = opc[1];
         end
         8'h09, 8'h0B: begin
            attr.known      = 1'b1;
            attr.has_modrm  = 1'b1;
            attr.reg_is_dst = opc[1];
         end
         8'h0C: begin
            attr.known   = 1'b1;
            attr.byte_op = 1'b1;
            attr.immk    = IMMK_BYTE;
         end
         8'h0D: begin
            attr.known = 1'b1;
            attr.immk  = IMMK_FULL;
         end
         8'h80: begin
            attr.known     = 1'b1;
            attr.has_modrm = 1'b1;
            attr.grp       = 1'b1;
            attr.byte_op   = 1'b1;
            attr.immk      = IMMK_BYTE;
         end
         8'h81: begin
            attr.known     = 1'b1;
            attr.has_modrm = 1'b1;
            attr.grp       = 1'b1;
            attr.immk      = IMMK_FULL;
         end
         8'h83: begin
            attr.known     = 1'b1;
            attr.has_modrm = 1'b1;
            attr.grp       = 1'b1;
            attr.immk      = IMMK_BYTE;
         end
         default: attr = '0;
      endcase
   end

endmodule

// File: rtl/ordec_imm_collect.sv
module ordec_imm_collect #(
   parameter int MAX_BYTES = 4,
   localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
   localparam int RAW_W    = 8 * MAX_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       byte_in,
   output logic [RAW_W-1:0] raw
);

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clr) begin
            lane_q <= '0;
         end else if (load && (idx == IDX_W'(g))) begin
            lane_q <= byte_in;
         end
      end
      assign raw[8*g +: 8] = lane_q;
   end

endmodule

// File: rtl/ordec_imm_ext.sv
module ordec_imm_ext #(
   parameter int RAW_BYTES = 4,
   parameter int OUT_W     = 64,
   localparam int RAW_W    = 8 * RAW_BYTES,
   localparam int LEN_W    = $clog2(RAW_BYTES + 1)
) (
   input  logic [RAW_W-1:0] raw,
   input  logic [LEN_W-1:0] nbytes,
   input  logic [1:0]       osz,
   output logic [OUT_W-1:0] ext_imm
);

   logic             sgn;
   logic [OUT_W-1:0] wide;

   always_comb begin
      sgn = 1'b0;
      for (int b = 1; b <= RAW_BYTES; b++) begin
         if (nbytes == LEN_W'(b)) sgn = raw[8*b-1];
      end
   end

   for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      localparam int MINC = (i < 8) ? 0 : (i < 16) ? 1 : (i < 32) ? 2 : 3;
      if (i < RAW_W) begin : g_raw
         assign wide[i] = (LEN_W'(i / 8) < nbytes) ? raw[i] : sgn;
      end else begin : g_sgn
         assign wide[i] = sgn;
      end
      if (i < 64) begin : g_keep
         assign ext_imm[i] = (osz >= 2'(MINC)) ? wide[i] : 1'b0;
      end else begin : g_zero
         assign ext_imm[i] = 1'b0;
      end
   end

endmodule

// File: rtl/or_byte_decoder.sv
module or_byte_decoder
   import ordec_pkg::*;
#(
   parameter int MAX_IMM_BYTES = 4,
   parameter int IMM_OUT_W     = 64,
   parameter int REG_SEL_W     = 4,
   localparam int IDX_W        = (MAX_IMM_BYTES > 1) ? $clog2(MAX_IMM_BYTES) : 1,
   localparam int LEN_W        = $clog2(MAX_IMM_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [7:0]           in_byte,
   output logic                 in_ready,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [1:0]           out_width,
   output logic [REG_SEL_W-1:0] out_dst,
   output logic                 out_dst_mem,
   output logic                 out_dst_hi,
   output logic [REG_SEL_W-1:0] out_src,
   output logic                 out_src_mem,
   output logic                 out_src_imm,
   output logic                 out_src_hi,
   output logic [IMM_OUT_W-1:0] out_imm,
   output logic                 out_ud
);

   if (MAX_IMM_BYTES != 4) begin : g_bad_imm
      $error("MAX_IMM_BYTES must be 4");
   end
   if (IMM_OUT_W != 64) begin : g_bad_out
      $error("IMM_OUT_W must be 64");
   end
   if (REG_SEL_W != 4) begin : g_bad_sel
      $error("REG_SEL_W must be 4");
   end

   st_e              st_q;
   logic             osz_pfx_q, lock_q, rex_q, rexw_q, rexr_q, rexb_q;
   opc_attr_t        attr_q, attr_in;
   osz_e             osz_q, osz_in;
   logic [7:0]       modrm_q;
   logic             bad_q;
   logic [IDX_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_in, len_q;
   logic             take, retire, is_pfx, opc_step;
   logic [8*MAX_IMM_BYTES-1:0] raw;

   assign in_ready  = (st_q != ST_DONE);
   assign out_valid = (st_q == ST_DONE);
   assign take      = in_valid && in_ready;
   assign retire    = out_valid && out_ready;

   assign is_pfx   = (in_byte == PFX_OSZ) || (in_byte == PFX_LOCK) ||
                     (in_byte[7:4] == REX_HI);
   assign opc_step = (st_q == ST_OPC) || ((st_q == ST_PFX) && !is_pfx);

   ordec_opc_class u_cls (
      .opc  (in_byte),
      .attr (attr_in)
   );

   always_comb begin
      if (attr_in.byte_op)  osz_in = OSZ_8;
      else if (rexw_q)      osz_in = OSZ_64;
      else if (osz_pfx_q)   osz_in = OSZ_16;
      else                  osz_in = OSZ_32;
   end

   assign len_in = LEN_W'(imm_bytes(attr_in.immk, osz_in));
   assign len_q  = LEN_W'(imm_bytes(attr_q.immk, osz_q));

   // state and captured fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_PFX;
         osz_pfx_q <= 1'b0;
         lock_q    <= 1'b0;
         rex_q     <= 1'b0;
         rexw_q    <= 1'b0;
         rexr_q    <= 1'b0;
         rexb_q    <= 1'b0;
         attr_q    <= '0;
         osz_q     <= OSZ_32;
         modrm_q   <= '0;
         bad_q     <= 1'b0;
         cnt_q     <= '0;
      end else if (retire) begin
         st_q      <= ST_PFX;
         osz_pfx_q <= 1'b0;
         lock_q    <= 1'b0;
         rex_q     <= 1'b0;
         rexw_q    <= 1'b0;
         rexr_q    <= 1'b0;
         rexb_q    <= 1'b0;
         bad_q     <= 1'b0;
         cnt_q     <= '0;
      end else if (take) begin
         if (opc_step) begin
            attr_q <= attr_in;
            osz_q  <= osz_in;
            cnt_q  <= '0;
            if (!attr_in.known)          st_q <= ST_DONE;
            else if (attr_in.has_modrm)  st_q <= ST_MODRM;
            else if (len_in != '0)       st_q <= ST_IMM;
            else                         st_q <= ST_DONE;
         end else begin
            case (st_q)
               ST_PFX: begin
                  if (in_byte == PFX_OSZ) begin
                     osz_pfx_q <= 1'b1;
                  end else if (in_byte == PFX_LOCK) begin
                     lock_q <= 1'b1;
                  end else begin
                     rex_q  <= 1'b1;
                     rexw_q <= in_byte[3];
                     rexr_q <= in_byte[2];
                     rexb_q <= in_byte[0];
                     st_q   <= ST_OPC;
                  end
               end
               ST_MODRM: begin
                  modrm_q <= in_byte;
                  if (attr_q.grp && (in_byte[5:3] != 3'd1)) begin
                     bad_q <= 1'b1;
                     st_q  <= ST_DONE;
                  end else if (len_q != '0) begin
                     st_q <= ST_IMM;
                  end else begin
                     st_q <= ST_DONE;
                  end
               end
               ST_IMM: begin
                  if ((LEN_W'(cnt_q) + LEN_W'(1)) == len_q) st_q <= ST_DONE;
                  else                                       cnt_q <= cnt_q + IDX_W'(1);
               end
               default: st_q <= st_q;
            endcase
         end
      end
   end

   ordec_imm_collect #(.MAX_BYTES(MAX_IMM_BYTES)) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (retire),
      .load    (take && (st_q == ST_IMM)),
      .idx     (cnt_q),
      .byte_in (in_byte),
      .raw     (raw)
   );

   ordec_imm_ext #(.RAW_BYTES(MAX_IMM_BYTES), .OUT_W(IMM_OUT_W)) u_ext (
      .raw     (raw),
      .nbytes  (len_q),
      .osz     (osz_q),
      .ext_imm (out_imm)
   );

   // operand routing of the held record
   logic                 mem_rm;
   logic [REG_SEL_W-1:0] reg_sel, rm_sel;

   assign mem_rm  = attr_q.has_modrm && (modrm_q[7:6] != 2'b11);
   assign reg_sel = {rexr_q, modrm_q[5:3]};
   assign rm_sel  = {rexb_q, modrm_q[2:0]};

   always_comb begin
      out_dst     = '0;
      out_src     = '0;
      out_dst_mem = 1'b0;
      out_src_mem = 1'b0;
      out_src_imm = 1'b0;
      if (!attr_q.has_modrm) begin
         out_src_imm = 1'b1;
      end else if (attr_q.grp) begin
         out_dst     = rm_sel;
         out_dst_mem = mem_rm;
         out_src_imm = 1'b1;
      end else if (attr_q.reg_is_dst) begin
         out_dst     = reg_sel;
         out_src     = rm_sel;
         out_src_mem = mem_rm;
      end else begin
         out_dst     = rm_sel;
         out_dst_mem = mem_rm;
         out_src     = reg_sel;
      end
   end

   assign out_width  = osz_q;
   assign out_dst_hi = attr_q.byte_op && !rex_q && !out_dst_mem && (out_dst[3:2] == 2'b01);
   assign out_src_hi = attr_q.byte_op && !rex_q && !out_src_mem && !out_src_imm &&
                       (out_src[3:2] == 2'b01);
   assign out_ud     = bad_q || !attr_q.known || (lock_q && !out_dst_mem);

endmodule

// File: rtl/ordec_chk.sv
module ordec_chk #(
   parameter int IMM_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [1:0]       out_width,
   input logic [3:0]       out_dst,
   input logic             out_dst_hi,
   input logic             out_src_mem,
   input logic             out_src_imm,
   input logic             out_src_hi,
   input logic [IMM_W-1:0] out_imm,
   input logic             out_ud
);

   // R11
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) &&
                                     $stable(out_dst) && $stable(out_ud) &&
                                     $stable(out_width)));

   // R11
   rec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   // R6
   imm8_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_width == 2'd0)) |-> ((out_imm >> 8) == '0));

   // R6
   imm16_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_width == 2'd1)) |-> ((out_imm >> 16) == '0));

   // R8
   hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_dst_hi || out_src_hi)) |-> (out_width == 2'd0));

   // R5
   imm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_src_imm) |-> !out_src_mem);

endmodule

bind or_byte_decoder ordec_chk #(.IMM_W(IMM_OUT_W)) u_ordec_chk (.*);

// File: tb/or_byte_decoder_bench.sv
module or_byte_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [1:0]  out_width;
   logic [3:0]  out_dst, out_src;
   logic        out_dst_mem, out_dst_hi, out_src_mem, out_src_imm, out_src_hi;
   logic [63:0] out_imm;
   logic        out_ud;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   or_byte_decoder u_or_byte_decoder (.*);

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic accept(input string req);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk(req, "valid after accept", 64'(out_valid), 64'd0);
   endtask

   task automatic expect_rec(input string req, input logic [1:0] w,
                             input logic [3:0] d, input logic dm, input logic dh,
                             input logic [3:0] s, input logic sm, input logic si,
                             input logic sh, input logic [63:0] imm, input logic ud);
      chk(req, "out_valid", 64'(out_valid), 64'd1);
      chk("R11", "in_ready stalled", 64'(in_ready), 64'd0);
      chk(req, "width", 64'(out_width), 64'(w));
      chk(req, "dst", 64'(out_dst), 64'(d));
      chk(req, "dst_mem", 64'(out_dst_mem), 64'(dm));
      chk(req, "dst_hi", 64'(out_dst_hi), 64'(dh));
      chk(req, "src", 64'(out_src), 64'(s));
      chk(req, "src_mem", 64'(out_src_mem), 64'(sm));
      chk(req, "src_imm", 64'(out_src_imm), 64'(si));
      chk(req, "src_hi", 64'(out_src_hi), 64'(sh));
      chk(req, "imm", out_imm, imm);
      chk(req, "ud", 64'(out_ud), 64'(ud));
      accept("R11");
   endtask

   task automatic expect_ud(input string req);
      chk(req, "out_valid", 64'(out_valid), 64'd1);
      chk(req, "in_ready stalled", 64'(in_ready), 64'd0);
      chk(req, "ud", 64'(out_ud), 64'd1);
      accept("R11");
   endtask

   // R1
   task automatic t_reset();
      chk("R1", "out_valid", 64'(out_valid), 64'd0);
      chk("R1", "in_ready", 64'(in_ready), 64'd1);
   endtask

   // R4 R3 R6
   task automatic t_acc();
      push(8'h0C); push(8'h5A);
      expect_rec("R4", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h5A, 0);
      push(8'h0C); push(8'h80);
      expect_rec("R6", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h80, 0);
      push(8'h0D); push(8'h34); push(8'h12); push(8'h78); push(8'h56);
      expect_rec("R4", 2'd2, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h56781234, 0);
      push(8'h66); push(8'h0D); push(8'h34); push(8'h12);
      expect_rec("R3", 2'd1, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h1234, 0);
      push(8'h48); push(8'h0D); push(8'h00); push(8'h00); push(8'h00); push(8'h80);
      expect_rec("R6", 2'd3, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'hFFFFFFFF80000000, 0);
      push(8'h66); push(8'h48); push(8'h0D); push(8'h01); push(8'h00); push(8'h00); push(8'h00);
      expect_rec("R3", 2'd3, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h1, 0);
   endtask

   // R5 R6 R8
   task automatic t_grp();
      push(8'h83); push(8'hC9); push(8'hF0);
      expect_rec("R5", 2'd2, 4'd1, 0, 0, 4'd0, 0, 1, 0, 64'hFFFFFFF0, 0);
      push(8'h66); push(8'h83); push(8'hC9); push(8'h80);
      expect_rec("R6", 2'd1, 4'd1, 0, 0, 4'd0, 0, 1, 0, 64'hFF80, 0);
      push(8'h48); push(8'h83); push(8'hC9); push(8'hFF);
      expect_rec("R6", 2'd3, 4'd1, 0, 0, 4'd0, 0, 1, 0, 64'hFFFFFFFFFFFFFFFF, 0);
      push(8'h41); push(8'h83); push(8'hC9); push(8'h01);
      expect_rec("R5", 2'd2, 4'd9, 0, 0, 4'd0, 0, 1, 0, 64'h1, 0);
      push(8'h66); push(8'h81); push(8'h0B); push(8'h34); push(8'h12);
      expect_rec("R5", 2'd1, 4'd3, 1, 0, 4'd0, 0, 1, 0, 64'h1234, 0);
      push(8'h81); push(8'hC9); push(8'h00); push(8'h00); push(8'h00); push(8'h80);
      expect_rec("R6", 2'd2, 4'd1, 0, 0, 4'd0, 0, 1, 0, 64'h80000000, 0);
      push(8'h80); push(8'hC8); push(8'h7F);
      expect_rec("R5", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h7F, 0);
      push(8'h80); push(8'hCC); push(8'h01);
      expect_rec("R8", 2'd0, 4'd4, 0, 1, 4'd0, 0, 1, 0, 64'h1, 0);
      push(8'h40); push(8'h80); push(8'hCC); push(8'h01);
      expect_rec("R8", 2'd0, 4'd4, 0, 0, 4'd0, 0, 1, 0, 64'h1, 0);
   endtask

   // R7 R8
   task automatic t_regreg();
      push(8'h08); push(8'hD8);
      expect_rec("R7", 2'd0, 4'd0, 0, 0, 4'd3, 0, 0, 0, 64'h0, 0);
      push(8'h08); push(8'hE0);
      expect_rec("R8", 2'd0, 4'd0, 0, 0, 4'd4, 0, 0, 1, 64'h0, 0);
      push(8'h0A); push(8'hE0);
      expect_rec("R8", 2'd0, 4'd4, 0, 1, 4'd0, 0, 0, 0, 64'h0, 0);
      push(8'h4C); push(8'h09); push(8'hD8);
      expect_rec("R7", 2'd3, 4'd0, 0, 0, 4'd11, 0, 0, 0, 64'h0, 0);
      push(8'h0B); push(8'h03);
      expect_rec("R7", 2'd2, 4'd0, 0, 0, 4'd3, 1, 0, 0, 64'h0, 0);
   endtask

   // R9 R2
   task automatic t_lock();
      push(8'hF0); push(8'h08); push(8'hD8);
      expect_rec("R9", 2'd0, 4'd0, 0, 0, 4'd3, 0, 0, 0, 64'h0, 1);
      push(8'hF0); push(8'h09); push(8'h03);
      expect_rec("R9", 2'd2, 4'd3, 1, 0, 4'd0, 0, 0, 0, 64'h0, 0);
      push(8'hF0); push(8'h0C); push(8'h11);
      expect_rec("R9", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h11, 1);
      push(8'hF0); push(8'h0B); push(8'h03);
      expect_rec("R9", 2'd2, 4'd0, 0, 0, 4'd3, 1, 0, 0, 64'h0, 1);
      push(8'hF0); push(8'h66); push(8'h09); push(8'h03);
      expect_rec("R2", 2'd1, 4'd3, 1, 0, 4'd0, 0, 0, 0, 64'h0, 0);
   endtask

   // R10 R2
   task automatic t_bad();
      push(8'h0F);
      expect_ud("R10");
      push(8'h0C); push(8'h22);
      expect_rec("R10", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h22, 0);
      push(8'h80); push(8'hC0);
      expect_ud("R10");
      push(8'h0C); push(8'h33);
      expect_rec("R10", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h33, 0);
      push(8'h48); push(8'h66);
      expect_ud("R2");
      push(8'h0C); push(8'h3C);
      expect_rec("R2", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h3C, 0);
   endtask

   // R11
   task automatic t_hold();
      push(8'h0C); push(8'h44);
      in_valid = 1'b1;
      in_byte  = 8'h0D;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R11", "held valid", 64'(out_valid), 64'd1);
         chk("R11", "held imm", out_imm, 64'h44);
      end
      in_valid = 1'b0;
      accept("R11");
      push(8'h0C); push(8'h55);
      expect_rec("R11", 2'd0, 4'd0, 0, 0, 4'd0, 0, 1, 0, 64'h55, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_acc();
      t_grp();
      t_regreg();
      t_lock();
      t_bad();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule